// File: doc/BRIEF.md
# Gated Slave-Select Decoder

This block turns a binary slave index from a transfer sequencer into one active-low select line out of many. A single gate stands between the decoder and the select outputs. While the gate is closed, every select sits inactive and the index register may be reloaded. The gate opens only after the index has been held for a programmable number of clock cycles. Because the index can never change while the gate is open, an index change cannot produce a pulse on a select line that was not asked for.

A supervisor sits in front of the gate. It watches the power-good, reset-complete and brown-out inputs. Power-good must stay high for a programmable run of consecutive cycles before the gate may open. Any loss of power-good, any drop of reset-complete and any brown-out closes the gate on the next clock edge. Recovery then passes through a safe state: the engine is disabled, all selects are held inactive and the index register is cleared. A request must then be present again and go through the full settle time before the gate reopens.

The decode can be built as a single level or as two cascaded levels (group, then member) by parameter. Every select output comes straight from a register.

Top module: `csel_gate_top`

## Requirements
- R1: While reset is asserted and right after it, every select (`cs_n`) is high and `gate_open` is low.
- R2: The gate stays closed until `pwr_good` has been sampled high on `pg_cycles` consecutive edges and `rst_done` is high. Let the first edge that samples `pwr_good` high (with `rst_done`, `req_valid` already high and no brown-out) be edge 0. The gate then opens on edge `pg_cycles + settle_cycles + 2`. A low `pwr_good` closes the gate on the next edge and restarts the count.
- R3: From the idle state, let the first edge that samples `req_valid` high be edge 0. The index is loaded on that edge and the gate opens on edge `settle_cycles + 1`. This holds for a `settle_cycles` value of 0 as well.
- R4: While the gate is open, exactly one select is low: bit number `req_addr` of `cs_n`. While the gate is closed, all bits of `cs_n` are high.
- R5: A different `req_addr` presented while the gate is open is deferred. The gate closes on the next edge with all selects high, the new index is loaded on the following edge, and the gate reopens on the new select after the full settle time. While the gate is open, the select does not change.
- R6: When `req_valid` goes low, the gate closes on the next edge.
- R7: A brown-out closes the gate on the next edge. The gate stays closed while the brown-out lasts. After it clears, power-good qualification and the settle time both run again from the start (same count as R2).
- R8: When `rst_done` drops, the gate closes on the next edge. When `rst_done` returns with power-good still qualified, the gate reopens on edge `settle_cycles + 2`, counting the first edge that samples `rst_done` high as edge 0.
- R9: `cs_n` and `gate_open` change only at rising clock edges. An input change between edges leaves them unchanged until the next edge.
- R10: In two-level decode, the upper `GRP_W` index bits pick a group and the lower bits pick a member within that group. The active select is still bit `req_addr` of `cs_n`, for every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Sequencer holds high to request the select for `req_addr` |
| req_addr | input | ADDR_W | Binary slave index |
| settle_cycles | input | SET_W | Extra hold cycles between loading the index and opening the gate |
| pg_cycles | input | PG_W | Consecutive high power-good samples needed |
| pwr_good | input | 1 | Supply good status |
| rst_done | input | 1 | System reset sequence complete |
| brown_out | input | 1 | Undervoltage detected |
| gate_open | output | 1 | Gate-open acknowledge to the sequencer |
| cs_n | output | 2**ADDR_W | Registered active-low selects |

## Verification
The bench builds the block with `ADDR_W=4` and `GRP_W=2`. This gives sixteen selects behind a two-level decode, so every group/member combination is reached by sweeping all indices. Both counter widths are 8 bits. The bench uses a power-good count of 5 and settle counts of 0 and 3. The short counts keep each exact edge count of R2, R3, R7 and R8 within a few cycles, and the zero setting exercises the shortest path to the open gate.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [1:0] {
        ST_SAFE   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_OPEN   = 2'd3
    } gate_st_e;

endpackage

// File: rtl/csel_supervisor.sv
module csel_supervisor #(
    parameter int PG_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_good,
    input  logic            rst_done,
    input  logic            brown_out,
    input  logic [PG_W-1:0] pg_cycles,
    output logic            sys_ok
);

    typedef struct packed {
        logic [PG_W-1:0] run;
    } sup_t;

    sup_t sup_d, sup_q;

    always_comb begin
        sup_d = sup_q;
        if (!pwr_good || brown_out) begin
            // any loss of supply or brown-out restarts qualification
            sup_d.run = '0;
        end else if (sup_q.run < pg_cycles) begin
            sup_d.run = sup_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_q <= '0;
        end else begin
            sup_q <= sup_d;
        end
    end

    // live inputs take part so that any fault reaches the gate at the next edge
    assign sys_ok = pwr_good && rst_done && !brown_out && (sup_q.run >= pg_cycles);

endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl
    import csel_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_ok,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SET_W-1:0]  settle_cycles,
    output logic              open_nx,
    output logic [ADDR_W-1:0] addr_nx,
    output logic              gate_open
);

    typedef struct packed {
        gate_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [SET_W-1:0]  cnt;
        logic              open;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.open = 1'b0;
        if (!sys_ok) begin
            // safe state: engine off, selects off, index re-initialised
            ctrl_d.st   = ST_SAFE;
            ctrl_d.addr = '0;
            ctrl_d.cnt  = '0;
        end else begin
            case (ctrl_q.st)
                ST_SAFE: begin
                    ctrl_d.st = ST_IDLE;
                end
                ST_IDLE: begin
                    if (req_valid) begin
                        ctrl_d.st   = ST_SETTLE;
                        ctrl_d.addr = req_addr;
                        ctrl_d.cnt  = '0;
                    end
                end
                ST_SETTLE: begin
                    if (!req_valid) begin
                        ctrl_d.st = ST_IDLE;
                    end else if (req_addr != ctrl_q.addr) begin
                        // gate still closed: reload and restart settling
                        ctrl_d.addr = req_addr;
                        ctrl_d.cnt  = '0;
                    end else if (ctrl_q.cnt >= settle_cycles) begin
                        ctrl_d.st   = ST_OPEN;
                        ctrl_d.open = 1'b1;
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (req_valid && (req_addr == ctrl_q.addr)) begin
                        ctrl_d.open = 1'b1;
                    end else begin
                        // close first; a new index is taken from idle next edge
                        ctrl_d.st = ST_IDLE;
                    end
                end
                default: begin
                    ctrl_d.st = ST_SAFE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_SAFE, addr: '0, cnt: '0, open: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign open_nx   = ctrl_d.open;
    assign addr_nx   = ctrl_d.addr;
    assign gate_open = ctrl_q.open;

endmodule

// File: rtl/csel_decode.sv
module csel_decode #(
    parameter int ADDR_W = 4,
    parameter int GRP_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 open_nx,
    input  logic [ADDR_W-1:0]    addr_nx,
    output logic [2**ADDR_W-1:0] cs_n
);

    localparam int NSEL = 2**ADDR_W;

    typedef struct packed {
        logic [NSEL-1:0] cs_n;
    } dec_t;

    dec_t            dec_d, dec_q;
    logic [NSEL-1:0] hot;

    generate
        if (GRP_W == 0) begin : g_flat
            for (genvar i = 0; i < NSEL; i++) begin : g_bit
                assign hot[i] = (addr_nx == ADDR_W'(i));
            end
        end else begin : g_tree
            localparam int MEM_W = ADDR_W - GRP_W;
            localparam int NGRP  = 2**GRP_W;
            localparam int NMEM  = 2**MEM_W;
            logic [NGRP-1:0] grp_hot;
            logic [NMEM-1:0] mem_hot;
            for (genvar g = 0; g < NGRP; g++) begin : g_grp
                assign grp_hot[g] = (addr_nx[ADDR_W-1:MEM_W] == GRP_W'(g));
            end
            for (genvar m = 0; m < NMEM; m++) begin : g_mem
                assign mem_hot[m] = (addr_nx[MEM_W-1:0] == MEM_W'(m));
            end
            for (genvar g = 0; g < NGRP; g++) begin : g_row
                for (genvar m = 0; m < NMEM; m++) begin : g_col
                    assign hot[g*NMEM+m] = grp_hot[g] & mem_hot[m];
                end
            end
        end
    endgenerate

    always_comb begin
        dec_d      = dec_q;
        dec_d.cs_n = open_nx ? ~hot : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '{cs_n: '1};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign cs_n = dec_q.cs_n;

endmodule

// File: rtl/csel_gate_top.sv
module csel_gate_top #(
    parameter int ADDR_W = 4,
    parameter int GRP_W  = 2,
    parameter int SET_W  = 8,
    parameter int PG_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SET_W-1:0]     settle_cycles,
    input  logic [PG_W-1:0]      pg_cycles,
    input  logic                 pwr_good,
    input  logic                 rst_done,
    input  logic                 brown_out,
    output logic                 gate_open,
    output logic [2**ADDR_W-1:0] cs_n
);

    logic              sys_ok;
    logic              open_nx;
    logic [ADDR_W-1:0] addr_nx;

    csel_supervisor #(.PG_W(PG_W)) u_sup (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .rst_done  (rst_done),
        .brown_out (brown_out),
        .pg_cycles (pg_cycles),
        .sys_ok    (sys_ok)
    );

    csel_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sys_ok        (sys_ok),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .settle_cycles (settle_cycles),
        .open_nx       (open_nx),
        .addr_nx       (addr_nx),
        .gate_open     (gate_open)
    );

    csel_decode #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_nx (open_nx),
        .addr_nx (addr_nx),
        .cs_n    (cs_n)
    );

endmodule

// File: rtl/csel_gate_chk.sv
module csel_gate_chk #(
    parameter int NSEL = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            pwr_good,
    input logic            rst_done,
    input logic            brown_out,
    input logic            gate_open,
    input logic [NSEL-1:0] cs_n
);

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (&cs_n && !gate_open);
        end
    end

    // R4
    one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> ($countones(~cs_n) == 1));

    // R4
    closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |-> (&cs_n));

    // R7
    brownout_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brown_out |=> !gate_open);

    // R2
    pg_loss_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !gate_open);

    // R8
    rstdone_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_done |=> !gate_open);

    // R6
    req_drop_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !gate_open);

    // R5
    open_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && $past(gate_open)) |-> $stable(cs_n));

    // R3
    open_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_open) |-> $past(req_valid));

endmodule

bind csel_gate_top csel_gate_chk #(.NSEL(2**ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .pwr_good  (pwr_good),
    .rst_done  (rst_done),
    .brown_out (brown_out),
    .gate_open (gate_open),
    .cs_n      (cs_n)
);

// File: tb/csel_gate_top_tb.sv
`timescale 1ns/1ps
module csel_gate_top_tb;

    localparam int AW = 4;
    localparam int GW = 2;
    localparam int SW = 8;
    localparam int PW = 8;
    localparam int N  = 2**AW;
    localparam int PG = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] settle_cycles = '0;
    logic [PW-1:0] pg_cycles = PW'(PG);
    logic          pwr_good = 1'b0;
    logic          rst_done = 1'b0;
    logic          brown_out = 1'b0;
    logic          gate_open;
    logic [N-1:0]  cs_n;

    int checks = 0;
    int errors = 0;
    int s_cur  = 3;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    csel_gate_top #(.ADDR_W(AW), .GRP_W(GW), .SET_W(SW), .PG_W(PW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .settle_cycles (settle_cycles),
        .pg_cycles     (pg_cycles),
        .pwr_good      (pwr_good),
        .rst_done      (rst_done),
        .brown_out     (brown_out),
        .gate_open     (gate_open),
        .cs_n          (cs_n)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_state(string req, bit exp_open, int a);
        logic [N-1:0] exp_cs;
        exp_cs = exp_open ? ~(N'(1) << a) : '1;
        checks++;
        if (gate_open !== exp_open || cs_n !== exp_cs) begin
            errors++;
            $display("FAIL %s: gate_open=%0b cs_n=%h expected gate_open=%0b cs_n=%h",
                     req, gate_open, cs_n, exp_open, exp_cs);
        end
    endtask

    // index already presented; closed through settle, open after it
    task automatic expect_open_after(string req, int a);
        step();
        expect_state(req, 1'b0, 0);
        for (int j = 0; j < s_cur; j++) begin
            step();
            expect_state(req, 1'b0, 0);
        end
        step();
        expect_state(req, 1'b1, a);
    endtask

    // after supply/brown-out recovery: closed for PG+2+S edges, then open
    task automatic expect_requalify(string req, int a);
        for (int e = 0; e < PG + 2 + s_cur; e++) begin
            step();
            expect_state(req, 1'b0, 0);
        end
        step();
        expect_state(req, 1'b1, a);
    endtask

    task automatic open_idx(string req, int a);
        req_valid = 1'b1;
        req_addr  = AW'(a);
        expect_open_after(req, a);
    endtask

    task automatic close_req();
        req_valid = 1'b0;
        step();
        expect_state("R6", 1'b0, 0);
    endtask

    task automatic t_reset();
        // R1
        repeat (3) step();
        expect_state("R1", 1'b0, 0);
        rst_n = 1'b1;
        step();
        expect_state("R1", 1'b0, 0);
    endtask

    task automatic t_pg_qualify();
        // R2: supply and reset status arrive together with the request
        s_cur         = 3;
        settle_cycles = SW'(s_cur);
        rst_done  = 1'b1;
        pwr_good  = 1'b1;
        req_valid = 1'b1;
        req_addr  = AW'(5);
        expect_requalify("R2", 5);
        close_req();
    endtask

    task automatic t_sweep();
        // R10, R3, R4: every index through the two-level decode, two settle counts
        for (int a = 0; a < N; a++) begin
            s_cur         = (a < N/2) ? 0 : 3;
            settle_cycles = SW'(s_cur);
            open_idx("R10", a);
            close_req();
        end
    endtask

    task automatic t_switch();
        // R5, R9
        s_cur         = 3;
        settle_cycles = SW'(s_cur);
        open_idx("R3", 3);
        req_addr = AW'(12);
        #1;
        expect_state("R9", 1'b1, 3);
        step();
        expect_state("R5", 1'b0, 0);
        expect_open_after("R5", 12);
        close_req();
    endtask

    task automatic t_brownout();
        // R7
        open_idx("R7", 7);
        brown_out = 1'b1;
        step();
        expect_state("R7", 1'b0, 0);
        repeat (3) begin
            step();
            expect_state("R7", 1'b0, 0);
        end
        brown_out = 1'b0;
        expect_requalify("R7", 7);
        close_req();
    endtask

    task automatic t_rstdone();
        // R8
        open_idx("R8", 9);
        rst_done = 1'b0;
        step();
        expect_state("R8", 1'b0, 0);
        step();
        expect_state("R8", 1'b0, 0);
        rst_done = 1'b1;
        step();
        expect_state("R8", 1'b0, 0);
        expect_open_after("R8", 9);
        close_req();
    endtask

    task automatic t_pg_drop();
        // R2: loss of power-good while open, then full requalification
        open_idx("R2", 2);
        pwr_good = 1'b0;
        step();
        expect_state("R2", 1'b0, 0);
        pwr_good = 1'b1;
        expect_requalify("R2", 2);
        close_req();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_pg_qualify();
        t_sweep();
        t_switch();
        t_brownout();
        t_rstdone();
        t_pg_drop();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule